// File: doc/BRIEF.md
# Interleave-Aware DRAM Address Decoder

This block turns a physical request address into the coordinates that a single DRAM controller needs: a column, bank, rank and row index. The controller owns one address range that may be striped with other controllers. Before any field is cut out, the block subtracts the range base and squeezes out the stripe-select bits that choose among the interleaved controllers. The decode then always works on a dense offset that starts at zero, and no channel count enters the field arithmetic.

All sizes are powers of two and are given as static log2 settings, so every division becomes a shift and every remainder a mask. A two-bit scheme select picks the field order. The open-page order keeps consecutive bursts in one row. The closed-page order spreads consecutive stripes over banks and ranks first. The legacy split-column code and the reserved code both decode like the open-page order. Results are registered: one cycle after a request strobe, the outputs carry the decoded values and a matching valid flag.

Top module: `dram_addr_decoder`

## Requirements
- R1: `out_valid` is low during and after reset and is high in exactly the cycles that follow a cycle with `in_valid` high. After reset, all data outputs read zero.
- R2: With `cfg_stripe_lg` = 0, `out_offset` equals `in_addr - cfg_base` modulo 2^ADDR_W.
- R3: With relative address `rel = in_addr - cfg_base`, the low `cfg_gran_lg` bits of `out_offset` equal those of `rel`. The `cfg_stripe_lg` bits of `rel` just above them are discarded, and the bits above those move down to sit directly on the low bits.
- R4: The low `cfg_burst_lg` bits of the offset affect no coordinate output.
- R5: For `cfg_map_sel` = 2'b00 (open page), the burst index `offset >> cfg_burst_lg` is split, from least to most significant, into column (`cfg_col_lg` bits), bank (`cfg_bank_lg`), rank (`cfg_rank_lg`) and row.
- R6: `cfg_map_sel` = 2'b01 gives outputs identical to 2'b00 for the same address and configuration.
- R7: For `cfg_map_sel` = 2'b10 (closed page), the burst index is split, from least to most significant, into low column (`cfg_col_stripe_lg` bits), bank, rank, high column (`cfg_col_lg - cfg_col_stripe_lg` bits) and row. The column output is `{high, low}`.
- R8: The row is the remaining value modulo 2^`cfg_row_lg`. Higher bits are dropped.
- R9: While `in_valid` is low, all data outputs keep their last values, whatever the address and configuration inputs do.
- R10: `cfg_map_sel` = 2'b11 decodes as the open-page order.
- R11: When `out_valid` is high, each coordinate is below 2 raised to its configured log2 size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; captures a new decode |
| in_addr | input | ADDR_W | Physical request address |
| cfg_base | input | ADDR_W | Start of the controller's address range |
| cfg_gran_lg | input | LG_W | log2 of the interleave granularity in bytes |
| cfg_stripe_lg | input | LG_W | log2 of the number of interleaved stripes |
| cfg_burst_lg | input | LG_W | log2 of bytes per column burst |
| cfg_col_lg | input | LG_W | log2 of columns per row buffer |
| cfg_col_stripe_lg | input | LG_W | log2 of columns per stripe (closed page), not above cfg_col_lg |
| cfg_bank_lg | input | LG_W | log2 of banks per rank |
| cfg_rank_lg | input | LG_W | log2 of ranks |
| cfg_row_lg | input | LG_W | log2 of rows per bank |
| cfg_map_sel | input | 2 | 00 open page, 01 legacy split column, 10 closed page, 11 reserved |
| out_valid | output | 1 | Decode result valid |
| out_offset | output | ADDR_W | Dense zero-based offset |
| out_col | output | COL_W | Column index |
| out_bank | output | BANK_W | Bank index |
| out_rank | output | RANK_W | Rank index |
| out_row | output | ROW_W | Row index |

## Verification
The bench targets stripe removal at several granularities and stripe counts. A decoder that leaves the select bits in place, or shifts by the wrong amount, produces an offset that jumps by a stripe's worth and misplaces every coordinate above it. It also covers a closed-page setting where the stripe holds the whole row buffer. Here a wrong high-column width would move row bits into the column. A small row setting checks the modulo wrap, which catches a row that keeps stray upper bits. Further checks cover the equivalence of the legacy and reserved scheme codes to open page, the insensitivity to byte-in-burst bits, and output hold while idle, which catches a register that loads on every cycle.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [1:0] {
    MAP_OPEN     = 2'b00,
    MAP_SPLITCOL = 2'b01,
    MAP_CLOSED   = 2'b10,
    MAP_RSVD     = 2'b11
  } map_sel_e;

endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dram_dense_offset.sv
module dram_dense_offset #(
  parameter int ADDR_W = 32,
  parameter int LG_W   = 6
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LG_W-1:0]   cfg_gran_lg,
  input  logic [LG_W-1:0]   cfg_stripe_lg,
  output logic [ADDR_W-1:0] dense
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] low_mask;
  logic [LG_W:0]     hi_shift;
  logic [ADDR_W-1:0] upper;

  always_comb begin
    rel      = in_addr - cfg_base;
    low_mask = (ONE << cfg_gran_lg) - ONE;
    hi_shift = {1'b0, cfg_gran_lg} + {1'b0, cfg_stripe_lg};
    upper    = (rel >> hi_shift) << cfg_gran_lg;
    dense    = upper | (rel & low_mask);
  end

endmodule

// File: rtl/dram_field_split.sv
module dram_field_split
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LG_W      = 6,
  parameter int COL_W     = 12,
  parameter int BANK_W    = 4,
  parameter int RANK_W    = 2,
  parameter int ROW_W     = 18,
  parameter bit CLOSED_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] dense,
  input  logic [LG_W-1:0]   cfg_burst_lg,
  input  logic [LG_W-1:0]   cfg_col_lg,
  input  logic [LG_W-1:0]   cfg_col_stripe_lg,
  input  logic [LG_W-1:0]   cfg_bank_lg,
  input  logic [LG_W-1:0]   cfg_rank_lg,
  input  logic [LG_W-1:0]   cfg_row_lg,
  input  logic [1:0]        cfg_map_sel,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic [RANK_W-1:0] rank,
  output logic [ROW_W-1:0]  row
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] lmask(input logic [LG_W-1:0] n);
    return (ONE << n) - ONE;
  endfunction

  logic [ADDR_W-1:0] burst_idx;

  // open-page order: column, bank, rank, row
  logic [ADDR_W-1:0] o_a1, o_a2, o_a3;
  logic [COL_W-1:0]  o_col;
  logic [BANK_W-1:0] o_bank;
  logic [RANK_W-1:0] o_rank;
  logic [ROW_W-1:0]  o_row;

  // closed-page order result
  logic [COL_W-1:0]  c_col;
  logic [BANK_W-1:0] c_bank;
  logic [RANK_W-1:0] c_rank;
  logic [ROW_W-1:0]  c_row;

  always_comb begin
    burst_idx = dense >> cfg_burst_lg;
    o_col  = COL_W'(burst_idx & lmask(cfg_col_lg));
    o_a1   = burst_idx >> cfg_col_lg;
    o_bank = BANK_W'(o_a1 & lmask(cfg_bank_lg));
    o_a2   = o_a1 >> cfg_bank_lg;
    o_rank = RANK_W'(o_a2 & lmask(cfg_rank_lg));
    o_a3   = o_a2 >> cfg_rank_lg;
    o_row  = ROW_W'(o_a3 & lmask(cfg_row_lg));
  end

  generate
    if (CLOSED_EN) begin : g_closed
      logic [ADDR_W-1:0] c_a1, c_a2, c_a3, c_a4;
      logic [ADDR_W-1:0] c_lo, c_hi;
      logic [LG_W-1:0]   hi_w;
      always_comb begin
        c_lo   = burst_idx & lmask(cfg_col_stripe_lg);
        c_a1   = burst_idx >> cfg_col_stripe_lg;
        c_bank = BANK_W'(c_a1 & lmask(cfg_bank_lg));
        c_a2   = c_a1 >> cfg_bank_lg;
        c_rank = RANK_W'(c_a2 & lmask(cfg_rank_lg));
        c_a3   = c_a2 >> cfg_rank_lg;
        hi_w   = cfg_col_lg - cfg_col_stripe_lg;
        c_hi   = c_a3 & lmask(hi_w);
        c_a4   = c_a3 >> hi_w;
        c_row  = ROW_W'(c_a4 & lmask(cfg_row_lg));
        c_col  = COL_W'((c_hi << cfg_col_stripe_lg) | c_lo);
      end
    end else begin : g_no_closed
      always_comb begin
        c_col  = o_col;
        c_bank = o_bank;
        c_rank = o_rank;
        c_row  = o_row;
      end
    end
  endgenerate

  always_comb begin
    if (map_sel_e'(cfg_map_sel) == MAP_CLOSED) begin
      col  = c_col;
      bank = c_bank;
      rank = c_rank;
      row  = c_row;
    end else begin
      col  = o_col;
      bank = o_bank;
      rank = o_rank;
      row  = o_row;
    end
  end

endmodule

// File: rtl/dram_coord_reg.sv
module dram_coord_reg #(
  parameter int ADDR_W = 32,
  parameter int COL_W  = 12,
  parameter int BANK_W = 4,
  parameter int RANK_W = 2,
  parameter int ROW_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] d_offset,
  input  logic [COL_W-1:0]  d_col,
  input  logic [BANK_W-1:0] d_bank,
  input  logic [RANK_W-1:0] d_rank,
  input  logic [ROW_W-1:0]  d_row,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_offset,
  output logic [COL_W-1:0]  q_col,
  output logic [BANK_W-1:0] q_bank,
  output logic [RANK_W-1:0] q_rank,
  output logic [ROW_W-1:0]  q_row
);

  logic              nx_valid;
  logic [ADDR_W-1:0] nx_offset;
  logic [COL_W-1:0]  nx_col;
  logic [BANK_W-1:0] nx_bank;
  logic [RANK_W-1:0] nx_rank;
  logic [ROW_W-1:0]  nx_row;

  always_comb begin
    nx_valid  = en;
    nx_offset = q_offset;
    nx_col    = q_col;
    nx_bank   = q_bank;
    nx_rank   = q_rank;
    nx_row    = q_row;
    if (en) begin
      nx_offset = d_offset;
      nx_col    = d_col;
      nx_bank   = d_bank;
      nx_rank   = d_rank;
      nx_row    = d_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_offset <= '0;
      q_col    <= '0;
      q_bank   <= '0;
      q_rank   <= '0;
      q_row    <= '0;
    end else begin
      q_valid  <= nx_valid;
      q_offset <= nx_offset;
      q_col    <= nx_col;
      q_bank   <= nx_bank;
      q_rank   <= nx_rank;
      q_row    <= nx_row;
    end
  end

endmodule

// File: rtl/dram_addr_decoder.sv
module dram_addr_decoder #(
  parameter int ADDR_W    = 32,
  parameter int COL_W     = 12,
  parameter int BANK_W    = 4,
  parameter int RANK_W    = 2,
  parameter int ROW_W     = 18,
  parameter bit CLOSED_EN = 1'b1,
  parameter int SYNC_STG  = 2,
  localparam int LG_W     = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LG_W-1:0]   cfg_gran_lg,
  input  logic [LG_W-1:0]   cfg_stripe_lg,
  input  logic [LG_W-1:0]   cfg_burst_lg,
  input  logic [LG_W-1:0]   cfg_col_lg,
  input  logic [LG_W-1:0]   cfg_col_stripe_lg,
  input  logic [LG_W-1:0]   cfg_bank_lg,
  input  logic [LG_W-1:0]   cfg_rank_lg,
  input  logic [LG_W-1:0]   cfg_row_lg,
  input  logic [1:0]        cfg_map_sel,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_offset,
  output logic [COL_W-1:0]  out_col,
  output logic [BANK_W-1:0] out_bank,
  output logic [RANK_W-1:0] out_rank,
  output logic [ROW_W-1:0]  out_row
);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] dense;
  logic [COL_W-1:0]  col_c;
  logic [BANK_W-1:0] bank_c;
  logic [RANK_W-1:0] rank_c;
  logic [ROW_W-1:0]  row_c;

  dram_rst_sync #(.STAGES(SYNC_STG)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dram_dense_offset #(.ADDR_W(ADDR_W), .LG_W(LG_W)) i_dense (
    .in_addr       (in_addr),
    .cfg_base      (cfg_base),
    .cfg_gran_lg   (cfg_gran_lg),
    .cfg_stripe_lg (cfg_stripe_lg),
    .dense         (dense)
  );

  dram_field_split #(
    .ADDR_W(ADDR_W), .LG_W(LG_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .RANK_W(RANK_W), .ROW_W(ROW_W), .CLOSED_EN(CLOSED_EN)
  ) i_split (
    .dense             (dense),
    .cfg_burst_lg      (cfg_burst_lg),
    .cfg_col_lg        (cfg_col_lg),
    .cfg_col_stripe_lg (cfg_col_stripe_lg),
    .cfg_bank_lg       (cfg_bank_lg),
    .cfg_rank_lg       (cfg_rank_lg),
    .cfg_row_lg        (cfg_row_lg),
    .cfg_map_sel       (cfg_map_sel),
    .col               (col_c),
    .bank              (bank_c),
    .rank              (rank_c),
    .row               (row_c)
  );

  dram_coord_reg #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .RANK_W(RANK_W), .ROW_W(ROW_W)
  ) i_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (in_valid),
    .d_offset (dense),
    .d_col    (col_c),
    .d_bank   (bank_c),
    .d_rank   (rank_c),
    .d_row    (row_c),
    .q_valid  (out_valid),
    .q_offset (out_offset),
    .q_col    (out_col),
    .q_bank   (out_bank),
    .q_rank   (out_rank),
    .q_row    (out_row)
  );

endmodule

// File: rtl/dram_addr_decoder_chk.sv
module dram_addr_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int COL_W  = 12,
  parameter int BANK_W = 4,
  parameter int RANK_W = 2,
  parameter int ROW_W  = 18,
  parameter int LG_W   = 6
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [LG_W-1:0]   cfg_gran_lg,
  input logic [LG_W-1:0]   cfg_stripe_lg,
  input logic [LG_W-1:0]   cfg_col_lg,
  input logic [LG_W-1:0]   cfg_bank_lg,
  input logic [LG_W-1:0]   cfg_rank_lg,
  input logic [LG_W-1:0]   cfg_row_lg,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_offset,
  input logic [COL_W-1:0]  out_col,
  input logic [BANK_W-1:0] out_bank,
  input logic [RANK_W-1:0] out_rank,
  input logic [ROW_W-1:0]  out_row
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] lmask(input logic [LG_W-1:0] n);
    return (ONE << n) - ONE;
  endfunction

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  p_flat_offset_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && cfg_stripe_lg == '0) |=>
      out_offset == ($past(in_addr) - $past(cfg_base)));

  p_low_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=>
      ((out_offset ^ ($past(in_addr) - $past(cfg_base))) & lmask(cfg_gran_lg)) == '0);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_offset) && $stable(out_col) && $stable(out_bank)
                   && $stable(out_rank) && $stable(out_row)));

  p_field_bounds_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> ((out_col >> cfg_col_lg) == '0 && (out_bank >> cfg_bank_lg) == '0
                   && (out_rank >> cfg_rank_lg) == '0 && (out_row >> cfg_row_lg) == '0));

endmodule

bind dram_addr_decoder dram_addr_decoder_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
  .RANK_W(RANK_W), .ROW_W(ROW_W), .LG_W(LG_W)
) i_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .in_valid      (in_valid),
  .in_addr       (in_addr),
  .cfg_base      (cfg_base),
  .cfg_gran_lg   (cfg_gran_lg),
  .cfg_stripe_lg (cfg_stripe_lg),
  .cfg_col_lg    (cfg_col_lg),
  .cfg_bank_lg   (cfg_bank_lg),
  .cfg_rank_lg   (cfg_rank_lg),
  .cfg_row_lg    (cfg_row_lg),
  .out_valid     (out_valid),
  .out_offset    (out_offset),
  .out_col       (out_col),
  .out_bank      (out_bank),
  .out_rank      (out_rank),
  .out_row       (out_row)
);

// File: tb/test_dram_addr_decoder.sv
`timescale 1ns/1ps
module test_dram_addr_decoder;

  localparam int ADDR_W = 32;
  localparam int COL_W  = 12;
  localparam int BANK_W = 4;
  localparam int RANK_W = 2;
  localparam int ROW_W  = 18;
  localparam int LG_W   = 6;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] base;
    logic [5:0]  g, s, b, c, cs, bk, rk, rw;
    logic [1:0]  sel;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h8000_1A40, 32'h8000_0000, 6'd8,  6'd1, 6'd6, 6'd4,  6'd2, 6'd3, 6'd1, 6'd10, 2'b00},
    '{32'h8000_1A40, 32'h8000_0000, 6'd8,  6'd1, 6'd6, 6'd4,  6'd2, 6'd3, 6'd1, 6'd10, 2'b10},
    '{32'h4123_4567, 32'h4000_0000, 6'd12, 6'd2, 6'd6, 6'd5,  6'd1, 6'd3, 6'd2, 6'd14, 2'b00},
    '{32'h4123_4567, 32'h4000_0000, 6'd12, 6'd2, 6'd6, 6'd5,  6'd1, 6'd3, 6'd2, 6'd14, 2'b10},
    '{32'h0003_FFC0, 32'h0000_0000, 6'd6,  6'd0, 6'd6, 6'd7,  6'd3, 6'd4, 6'd0, 6'd12, 2'b00},
    '{32'h0FFF_FF80, 32'h0000_0000, 6'd7,  6'd3, 6'd5, 6'd6,  6'd6, 6'd2, 6'd1, 6'd3,  2'b10},
    '{32'h2000_0000, 32'h2000_0000, 6'd8,  6'd2, 6'd6, 6'd4,  6'd2, 6'd3, 6'd1, 6'd10, 2'b10},
    '{32'hFFFF_FFC0, 32'hC000_0000, 6'd10, 6'd1, 6'd6, 6'd10, 6'd4, 6'd4, 6'd2, 6'd16, 2'b01}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [ADDR_W-1:0] in_addr, cfg_base;
  logic [LG_W-1:0]   cfg_gran_lg, cfg_stripe_lg, cfg_burst_lg, cfg_col_lg;
  logic [LG_W-1:0]   cfg_col_stripe_lg, cfg_bank_lg, cfg_rank_lg, cfg_row_lg;
  logic [1:0]        cfg_map_sel;
  logic              out_valid;
  logic [ADDR_W-1:0] out_offset;
  logic [COL_W-1:0]  out_col;
  logic [BANK_W-1:0] out_bank;
  logic [RANK_W-1:0] out_rank;
  logic [ROW_W-1:0]  out_row;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dram_addr_decoder i_dram_addr_decoder (
    .clk, .rst_n, .in_valid, .in_addr, .cfg_base, .cfg_gran_lg, .cfg_stripe_lg,
    .cfg_burst_lg, .cfg_col_lg, .cfg_col_stripe_lg, .cfg_bank_lg, .cfg_rank_lg,
    .cfg_row_lg, .cfg_map_sel, .out_valid, .out_offset, .out_col, .out_bank,
    .out_rank, .out_row
  );

  task automatic check(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] pack_out();
    return {out_offset, 20'(out_col), 12'(out_bank), 12'(out_rank), 20'(out_row)};
  endfunction

  // reference model written with division and remainder
  function automatic logic [95:0] model(input vec_t v);
    longint unsigned rel, gsz, ssz, dense, a, ccnt, cs, nb, nr, nw, lo, hi;
    longint unsigned col, bank, rank, row;
    rel   = longint'(32'(v.addr - v.base));
    gsz   = 64'd1 << v.g;
    ssz   = 64'd1 << v.s;
    dense = (rel / (gsz * ssz)) * gsz + rel % gsz;
    a     = dense / (64'd1 << v.b);
    ccnt  = 64'd1 << v.c;
    cs    = 64'd1 << v.cs;
    nb    = 64'd1 << v.bk;
    nr    = 64'd1 << v.rk;
    nw    = 64'd1 << v.rw;
    if (v.sel == 2'b10) begin
      lo = a % cs;           a = a / cs;
      bank = a % nb;         a = a / nb;
      rank = a % nr;         a = a / nr;
      hi = a % (ccnt / cs);  a = a / (ccnt / cs);
      row = a % nw;
      col = hi * cs + lo;
    end else begin
      col  = a % ccnt; a = a / ccnt;
      bank = a % nb;   a = a / nb;
      rank = a % nr;   a = a / nr;
      row  = a % nw;
    end
    return {32'(dense), 20'(col), 12'(bank), 12'(rank), 20'(row)};
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    in_valid          = 1'b1;
    in_addr           = v.addr;
    cfg_base          = v.base;
    cfg_gran_lg       = v.g;
    cfg_stripe_lg     = v.s;
    cfg_burst_lg      = v.b;
    cfg_col_lg        = v.c;
    cfg_col_stripe_lg = v.cs;
    cfg_bank_lg       = v.bk;
    cfg_rank_lg       = v.rk;
    cfg_row_lg        = v.rw;
    cfg_map_sel       = v.sel;
    @(negedge clk);
    in_valid          = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    logic [95:0] ref0, hold;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0; cfg_base = '0;
    cfg_gran_lg = '0; cfg_stripe_lg = '0; cfg_burst_lg = '0; cfg_col_lg = '0;
    cfg_col_stripe_lg = '0; cfg_bank_lg = '0; cfg_rank_lg = '0; cfg_row_lg = '0;
    cfg_map_sel = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && pack_out() == '0, "R1 reset state",
          {95'(0), out_valid} | pack_out(), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", 96'(out_valid), 96'd0);

    // table walk: R3 R5 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      check(out_valid == 1'b1 && pack_out() == model(VECS[i]),
            $sformatf("R3/R5/R7/R8/R11 vector %0d", i), pack_out(), model(VECS[i]));
    end

    // hand-worked values, open page: offset 0xD40 col 5 bank 3 rank 0 row 0
    drive(VECS[0]);
    check(pack_out() == {32'hD40, 20'd5, 12'd3, 12'd0, 20'd0}, "R5 R3 hand open",
          pack_out(), {32'hD40, 20'd5, 12'd3, 12'd0, 20'd0});
    // closed page: col 1 bank 5 rank 1 row 0
    drive(VECS[1]);
    check(pack_out() == {32'hD40, 20'd1, 12'd5, 12'd1, 20'd0}, "R7 hand closed",
          pack_out(), {32'hD40, 20'd1, 12'd5, 12'd1, 20'd0});

    // R1: valid drops the cycle after the strobe goes low
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid drop", 96'(out_valid), 96'd0);

    // R2: no stripes -> offset is address minus base
    v = VECS[2]; v.s = 6'd0; v.sel = 2'b00;
    drive(v);
    check(out_offset == 32'h0123_4567, "R2 flat offset",
          96'(out_offset), 96'(32'h0123_4567));

    // R6: legacy split-column code equals open page
    v = VECS[2]; v.sel = 2'b00;
    drive(v);
    ref0 = pack_out();
    v.sel = 2'b01;
    drive(v);
    check(pack_out() == ref0, "R6 split-column equals open", pack_out(), ref0);

    // R10: reserved code equals open page
    v.sel = 2'b11;
    drive(v);
    check(pack_out() == ref0, "R10 reserved equals open", pack_out(), ref0);

    // R4: byte-in-burst bits do not move coordinates
    v = VECS[2]; v.addr = 32'h4123_4540;
    drive(v);
    ref0 = pack_out();
    v.addr = 32'h4123_457F;
    drive(v);
    check(pack_out()[63:0] == ref0[63:0], "R4 burst bits ignored",
          96'(pack_out()[63:0]), 96'(ref0[63:0]));

    // R8: narrow row setting wraps
    v = VECS[7]; v.rw = 6'd2; v.sel = 2'b00;
    drive(v);
    check(pack_out() == model(v) && out_row < 18'd4, "R8 row wrap",
          pack_out(), model(v));

    // R9: outputs hold while idle despite input churn
    hold = pack_out();
    @(negedge clk);
    in_addr = 32'h1234_5678; cfg_map_sel = 2'b10; cfg_base = 32'h0;
    repeat (3) @(negedge clk);
    check(pack_out() == hold && out_valid == 1'b0, "R9 hold while idle",
          pack_out(), hold);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && pack_out() == '0, "R1 reset clears",
          pack_out(), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule